// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Hidden and Forced Refresh

This block decides when a DRAM row is refreshed, inside a memory controller that already runs the processor's own accesses. A slow, free-running refresh-period clock marks out refresh periods of about 16 µs. The block samples that clock by level after bringing it into the fast cycle-clock domain. While the period clock is high, a refresh window is open. If the processor starts a cycle to some other device during the window, with the DRAM chip-select inactive and the processor row strobe low, the block takes that cycle to refresh one row. The refresh counter drives the address, and all RAS lines pulse low for as long as the processor's strobe is low.

Only one such hidden refresh is taken in each period. If a period closes with no hidden refresh, the block raises a refresh request after the period clock falls. The system grants the request by pulling the acknowledge input low and holding off further DRAM accesses. The block then runs a forced refresh timed entirely by the cycle clock: an address setup cycle, a RAS pulse of a fixed number of cycles, and a precharge interval. After that it drops the request and hands control back.

The refresh row counter wraps around. An address-select output tells the surrounding address multiplexer when the refresh row, rather than the processor address, must reach the DRAM.

Top module: `dram_refresh_sched`

## Requirements
- R1: Out of reset, all RAS lines are high, refresh_req is 0, addr_from_refresh is 0 and refresh_row is 0.
- R2: A hidden refresh starts only while the synchronised period clock is high, cs_n is 1 and row_strobe_n is 0. With cs_n at 0, no RAS line moves.
- R3: A refresh first raises addr_from_refresh for one cycle with RAS high. Then all RAS lines go low in the same cycle. In a hidden refresh they stay low until row_strobe_n returns to 1.
- R4: refresh_row increases by exactly one each time a refresh RAS pulse ends, and wraps from 2^ROW_W-1 to 0.
- R5: After one hidden refresh, further qualifying cycles in the same period leave RAS high and refresh_row unchanged.
- R6: If a period passes with no refresh, refresh_req goes to 1 within five cycles of the period clock going low. If a hidden refresh did occur, refresh_req stays 0.
- R7: With refresh_req at 1 and refresh_ack_n at 0, the block holds RAS low for exactly RAS_CYC cycles, then high for PRE_CYC cycles with refresh_req still 1. It then clears refresh_req and addr_from_refresh.
- R8: The period clock passes two synchronising flops. A qualifying cycle already under way when the period clock rises starts a refresh on the same cycle the rise is detected: addr_from_refresh is 1 at the third falling cycle-clock edge after the period clock goes high.
- R9: While refresh_req is 1, qualifying processor cycles do not start a hidden refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock; all state and the forced refresh timing use it |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_clk | input | 1 | Refresh-period clock, asynchronous to clk, sampled by level |
| cs_n | input | 1 | DRAM chip-select from the processor, active low |
| row_strobe_n | input | 1 | Processor row strobe that marks a bus cycle, active low |
| refresh_ack_n | input | 1 | System grant for a forced refresh, active low |
| refresh_row | output | ROW_W | Row address for the current or next refresh |
| addr_from_refresh | output | 1 | 1 while refresh_row must drive the DRAM address |
| ras_n | output | NUM_RAS | Row strobes to the DRAM banks, active low |
| refresh_req | output | 1 | Request for a forced refresh |

## Verification
Two events can land on the same cycle. One is the rising period edge, which clears the refreshed-this-period flag. The other is a qualifying processor cycle, which starts a hidden refresh. The bench sets both up by holding cs_n high and row_strobe_n low before it raises the period clock, so the rise and the qualifying condition are seen together. It then checks that addr_from_refresh appears on the exact cycle that the two-flop path and a single state register predict, not one cycle later, and that the refresh then counts as the period's one hidden refresh.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

   typedef enum logic [2:0] {
      RS_IDLE  = 3'd0,
      RS_HADDR = 3'd1,
      RS_HRAS  = 3'd2,
      RS_FADDR = 3'd3,
      RS_FRAS  = 3'd4,
      RS_FPRE  = 3'd5
   } rs_state_t;

endpackage

// File: rtl/refresh_sync.sv
module refresh_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("refresh_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ROW_W-1:0] row
);

   if (ROW_W < 1) begin : g_bad_width
      $error("refresh_row_ctr: ROW_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (inc) row <= row + ROW_W'(1);
   end

   // R4: the row only ever moves forward by one, wrapping modulo 2^ROW_W
   assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row) |-> (row == $past(row) + ROW_W'(1)));

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
   import refresh_pkg::*;
#(
   parameter int RAS_CYC = 3,
   parameter int PRE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic win,
   input  logic win_rise,
   input  logic win_fall,
   input  logic cs_n,
   input  logic row_strobe_n,
   input  logic ack_n,
   output logic addr_sel,
   output logic ras_low,
   output logic row_inc,
   output logic req
);

   localparam int MAXC = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
   localparam int TW   = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [TW-1:0] RAS_LAST = TW'(RAS_CYC - 1);
   localparam logic [TW-1:0] PRE_LAST = TW'(PRE_CYC - 1);

   if (RAS_CYC < 1) begin : g_bad_ras
      $error("refresh_seq: RAS_CYC must be at least 1");
   end
   if (PRE_CYC < 2) begin : g_bad_pre
      $error("refresh_seq: PRE_CYC must be at least 2");
   end

   rs_state_t st, st_nxt;
   logic [TW-1:0] tmr;
   logic done_q, req_q;
   logic done_eff, hidden_go, force_go, force_end;

   // a rise in this very cycle already reopens the window
   assign done_eff  = done_q & ~win_rise;
   assign hidden_go = (st == RS_IDLE) && win && !done_eff && !req_q
                      && cs_n && !row_strobe_n;
   assign force_go  = (st == RS_IDLE) && req_q && !ack_n;
   assign force_end = (st == RS_FPRE) && (tmr == PRE_LAST);

   always_comb begin
      st_nxt = st;
      unique case (st)
         RS_IDLE:  if (force_go) st_nxt = RS_FADDR;
                   else if (hidden_go) st_nxt = RS_HADDR;
         RS_HADDR: st_nxt = RS_HRAS;
         RS_HRAS:  if (row_strobe_n) st_nxt = RS_IDLE;
         RS_FADDR: st_nxt = RS_FRAS;
         RS_FRAS:  if (tmr == RAS_LAST) st_nxt = RS_FPRE;
         RS_FPRE:  if (tmr == PRE_LAST) st_nxt = RS_IDLE;
         default:  st_nxt = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RS_IDLE;
         tmr <= '0;
      end else begin
         st <= st_nxt;
         if (st_nxt != st) tmr <= '0;
         else if (st == RS_FRAS || st == RS_FPRE) tmr <= tmr + TW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         if (hidden_go || force_end) done_q <= 1'b1;
         else if (win_rise)          done_q <= 1'b0;

         if (force_end)                        req_q <= 1'b0;
         else if (win_fall && !done_q)         req_q <= 1'b1;
      end
   end

   assign addr_sel = (st != RS_IDLE);
   assign ras_low  = (st == RS_HRAS) || (st == RS_FRAS);
   assign row_inc  = ((st == RS_HRAS) && row_strobe_n) ||
                     ((st == RS_FRAS) && (tmr == RAS_LAST));
   assign req      = req_q;

   // R3: strobes only fall after a cycle of refresh address
   assert_addr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_low) |-> $past(addr_sel));

   // R3: a hidden pulse holds while the processor strobe is still low
   assert_hidden_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_low && !row_strobe_n && st == RS_HRAS) |=> ras_low);

   // R6: a new request is always caused by a falling period edge
   assert_req_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(win_fall));

   // R7: the request is withdrawn only with the strobes already released
   assert_req_drop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> (!ras_low && !$past(ras_low)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
   parameter int ROW_W       = 8,
   parameter int NUM_RAS     = 4,
   parameter int RAS_CYC     = 3,
   parameter int PRE_CYC     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               period_clk,
   input  logic               cs_n,
   input  logic               row_strobe_n,
   input  logic               refresh_ack_n,
   output logic [ROW_W-1:0]   refresh_row,
   output logic               addr_from_refresh,
   output logic [NUM_RAS-1:0] ras_n,
   output logic               refresh_req
);

   if (NUM_RAS < 1) begin : g_bad_ras_count
      $error("dram_refresh_sched: NUM_RAS must be positive");
   end

   logic win_s, win_d, win_rise, win_fall;
   logic ras_low, row_inc;

   refresh_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (period_clk),
      .q     (win_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_d <= 1'b0;
      else        win_d <= win_s;
   end

   assign win_rise = win_s & ~win_d;
   assign win_fall = ~win_s & win_d;

   refresh_seq #(.RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .win          (win_s),
      .win_rise     (win_rise),
      .win_fall     (win_fall),
      .cs_n         (cs_n),
      .row_strobe_n (row_strobe_n),
      .ack_n        (refresh_ack_n),
      .addr_sel     (addr_from_refresh),
      .ras_low      (ras_low),
      .row_inc      (row_inc),
      .req          (refresh_req)
   );

   refresh_row_ctr #(.ROW_W(ROW_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (row_inc),
      .row   (refresh_row)
   );

   assign ras_n = {NUM_RAS{~ras_low}};

endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;

   localparam int ROW_W = 8;
   localparam int NRAS  = 4;
   localparam int RASC  = 3;
   localparam int PREC  = 2;
   localparam logic [NRAS-1:0] RAS_OFF = '1;
   localparam logic [NRAS-1:0] RAS_ON  = '0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic period_clk = 1'b0;
   logic cs_n = 1'b0;
   logic row_strobe_n = 1'b1;
   logic refresh_ack_n = 1'b1;
   logic [ROW_W-1:0] refresh_row;
   logic addr_from_refresh;
   logic [NRAS-1:0] ras_n;
   logic refresh_req;

   int n_chk = 0;
   int n_fail = 0;
   int exp_row = 0;

   always #2 clk = ~clk;

   dram_refresh_sched #(.ROW_W(ROW_W), .NUM_RAS(NRAS), .RAS_CYC(RASC),
                        .PRE_CYC(PREC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .period_clk(period_clk), .cs_n(cs_n),
      .row_strobe_n(row_strobe_n), .refresh_ack_n(refresh_ack_n),
      .refresh_row(refresh_row), .addr_from_refresh(addr_from_refresh),
      .ras_n(ras_n), .refresh_req(refresh_req));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one complete hidden refresh in an open window; checks R3 and R4 timing
   task automatic do_hidden(input bit verbose);
      @(negedge clk); cs_n = 1'b1; row_strobe_n = 1'b0;
      @(negedge clk);
      if (verbose) begin
         chk("R3 addr select before strobes", addr_from_refresh, 1);
         chk("R3 strobes still high", ras_n, RAS_OFF);
         chk("R3 row on address", refresh_row, exp_row);
      end
      @(negedge clk);
      if (verbose) chk("R3 all strobes low together", ras_n, RAS_ON);
      step(2);
      if (verbose) chk("R3 strobes held while row strobe low", ras_n, RAS_ON);
      row_strobe_n = 1'b1;
      @(negedge clk);
      exp_row = (exp_row + 1) % (1 << ROW_W);
      if (verbose) begin
         chk("R3 strobes released", ras_n, RAS_OFF);
         chk("R4 row advanced", refresh_row, exp_row);
      end
      cs_n = 1'b0;
   endtask

   task automatic t_reset();
      step(1);
      chk("R1 reset ras", ras_n, RAS_OFF);
      chk("R1 reset req", refresh_req, 0);
      chk("R1 reset addr select", addr_from_refresh, 0);
      chk("R1 reset row", refresh_row, 0);
   endtask

   task automatic t_hidden_once();
      period_clk = 1'b1; step(4);
      do_hidden(1'b1);
      // R5: second qualifying cycle in the same period
      cs_n = 1'b1; row_strobe_n = 1'b0; step(4);
      chk("R5 repeat ignored ras", ras_n, RAS_OFF);
      chk("R5 repeat ignored row", refresh_row, exp_row);
      row_strobe_n = 1'b1; cs_n = 1'b0;
      period_clk = 1'b0; step(6);
      chk("R6 no request after refreshed period", refresh_req, 0);
   endtask

   task automatic t_selected_then_forced();
      int lo;
      int pre;
      period_clk = 1'b1; step(4);
      cs_n = 1'b0; row_strobe_n = 1'b0; step(4);
      chk("R2 selected cycle gives no refresh", ras_n, RAS_OFF);
      chk("R2 addr select idle", addr_from_refresh, 0);
      row_strobe_n = 1'b1;
      period_clk = 1'b0; step(5);
      chk("R6 request after missed period", refresh_req, 1);
      // R9: qualifying cycle while request pending
      period_clk = 1'b1; step(4);
      cs_n = 1'b1; row_strobe_n = 1'b0; step(4);
      chk("R9 no hidden while request pending", ras_n, RAS_OFF);
      chk("R9 row unchanged", refresh_row, exp_row);
      row_strobe_n = 1'b1; cs_n = 1'b0;
      period_clk = 1'b0; step(3);
      refresh_ack_n = 1'b0;
      lo = 0; pre = 0;
      for (int i = 0; i < 20 && ras_n !== RAS_ON; i++) @(negedge clk);
      while (ras_n === RAS_ON && lo < 20) begin lo++; @(negedge clk); end
      exp_row = (exp_row + 1) % (1 << ROW_W);
      while (ras_n === RAS_OFF && refresh_req === 1'b1 && pre < 20) begin pre++; @(negedge clk); end
      chk("R7 forced RAS width", lo, RASC);
      chk("R7 precharge with request held", pre, PREC);
      chk("R7 request cleared", refresh_req, 0);
      chk("R7 addr select released", addr_from_refresh, 0);
      chk("R4 row after forced refresh", refresh_row, exp_row);
      refresh_ack_n = 1'b1;
      step(2);
   endtask

   task automatic t_rise_collision();
      // previous period: hidden refresh so the flag is set entering the rise
      period_clk = 1'b1; step(4);
      do_hidden(1'b0);
      period_clk = 1'b0; step(5);
      cs_n = 1'b1; row_strobe_n = 1'b0; step(2);
      chk("R8 idle before rise", addr_from_refresh, 0);
      period_clk = 1'b1;
      step(2);
      chk("R8 not yet started", addr_from_refresh, 0);
      step(1);
      chk("R8 start on rise cycle", addr_from_refresh, 1);
      step(1);
      chk("R8 strobes low", ras_n, RAS_ON);
      row_strobe_n = 1'b1;
      step(1);
      exp_row = (exp_row + 1) % (1 << ROW_W);
      chk("R8 row advanced", refresh_row, exp_row);
      row_strobe_n = 1'b0; step(4);
      chk("R5 collision counted as period refresh", ras_n, RAS_OFF);
      row_strobe_n = 1'b1; cs_n = 1'b0;
      period_clk = 1'b0; step(5);
   endtask

   task automatic t_wrap();
      int guard = 0;
      while (exp_row != 0 && guard < 300) begin
         guard++;
         period_clk = 1'b1; step(3);
         do_hidden(1'b0);
         period_clk = 1'b0; step(3);
      end
      chk("R4 row wrapped to zero", refresh_row, 0);
      chk("R6 no request during wrap run", refresh_req, 0);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_hidden_once();
      t_selected_then_forced();
      t_rise_collision();
      t_wrap();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule